// File: doc/BRIEF.md
# Memory Aperture Decoder

This block decides, for every address presented to it, whether that address lands inside the window of the address space that belongs to external SDRAM. The window is set by two registers: a lower bound (base) and an exclusive upper bound (limit). Both registers work at a coarse granularity. At the default parameters a granule is 64 KB, so each register stores only its upper address bits. The window therefore need not be a power of two in size. It only has to be a whole number of granules.

The lookup path is purely combinational. An address arrives on `addr`, and in the same cycle `hit` and `offset` report whether the address is inside the window and how far it sits above the base. The two registers sit behind a plain register port at two fixed word offsets. Reads on that port are combinational. A write changes the decode from the next cycle on. After reset the window covers the first 1 MB of the address space. The lookup is a pure function of its inputs and has no flow to stall, so it has no valid/ready handshake and never applies back-pressure.

Top module: `aperture_decoder`

## Requirements
- R1: After reset, the base register reads 0 and the limit register reads 0x0010_0000 (RST_LIMIT_G = 0x10 granules), so addresses 0 up to but not including 0x0010_0000 hit.
- R2: `hit` is 1 exactly when base <= addr < limit, where both bounds are full byte addresses. The address equal to the limit does not hit.
- R3: When limit <= base, the window is empty and no address hits.
- R4: While `hit` is 1, `offset` equals addr minus base. While `hit` is 0, `offset` is 0.
- R5: Each register keeps only bits [ADDR_W-1:GRAN_W] of a write. Bits [GRAN_W-1:0] are ignored on write and always read as 0.
- R6: The base register is at register offset 0x10_0000 and the limit register is at 0x10_0004. A read of any other offset returns 0, and a write to any other offset changes neither register.
- R7: A write with `wr_en` high is taken at the rising clock edge. The decode of `hit` uses the old value up to that edge and the new value after it.
- R8: Windows whose size in granules is not a power of two, and windows that reach the topmost granule below the limit, decode exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset for reads and writes |
| wr_data | input | ADDR_W | Register write data |
| rd_data | output | ADDR_W | Combinational read data for `reg_addr` |
| addr | input | ADDR_W | Address to classify |
| hit | output | 1 | Address is inside the window |
| offset | output | ADDR_W | Address minus base while hit, else 0 |

## Verification
The bench builds the decoder with ADDR_W = 12 and GRAN_W = 4. That gives 256 granules of 16 bytes, and the reset window of 0x10 granules then spans addresses 0x000 to 0x0FF. At this size every one of the 4096 addresses can be swept under each programmed window. The sweeps cover the reset window, a non-power-of-two window, equal and inverted bounds, and windows touching either end of the space. Each sweep therefore observes both edges of the half-open compare and the offset arithmetic at every address. The register-port tests use the same small space to check masking of the low bits, the handling of unmapped offsets, and the cycle in which a write starts to affect the decode.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LIMIT = 2'd2
  } ap_sel_e;
endpackage

// File: rtl/ap_regfile.sv
module ap_regfile #(
  parameter int          ADDR_W      = 32,
  parameter int          GRAN_W      = 16,
  parameter int          RA_W        = 21,
  parameter logic [RA_W-1:0] BASE_OFS  = 21'h10_0000,
  parameter logic [RA_W-1:0] LIMIT_OFS = 21'h10_0004,
  parameter int          RST_BASE_G  = 0,
  parameter int          RST_LIMIT_G = 'h10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [ADDR_W-1:0]        wr_data,
  output logic [ADDR_W-1:0]        rd_data,
  output logic [ADDR_W-GRAN_W-1:0] base_g,
  output logic [ADDR_W-GRAN_W-1:0] limit_g
);
  import ap_pkg::*;
  localparam int GW = ADDR_W - GRAN_W;

  ap_sel_e sel;

  always_comb begin
    if (reg_addr == BASE_OFS)       sel = SEL_BASE;
    else if (reg_addr == LIMIT_OFS) sel = SEL_LIMIT;
    else                            sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_g  <= GW'(RST_BASE_G);
      limit_g <= GW'(RST_LIMIT_G);
    end else if (wr_en) begin
      if (sel == SEL_BASE)  base_g  <= wr_data[ADDR_W-1:GRAN_W];
      if (sel == SEL_LIMIT) limit_g <= wr_data[ADDR_W-1:GRAN_W];
    end
  end

  always_comb begin
    case (sel)
      SEL_BASE:  rd_data = {base_g,  {GRAN_W{1'b0}}};
      SEL_LIMIT: rd_data = {limit_g, {GRAN_W{1'b0}}};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ap_window.sv
module ap_window #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-GRAN_W-1:0] base_g,
  input  logic [ADDR_W-GRAN_W-1:0] limit_g,
  output logic                     hit
);
  localparam int GW = ADDR_W - GRAN_W;
  logic [GW-1:0] addr_g;
  logic          above_base, below_limit;

  assign addr_g      = addr[ADDR_W-1:GRAN_W];
  assign above_base  = (addr_g >= base_g);
  assign below_limit = (addr_g <  limit_g);
  // an inverted or equal pair can never satisfy both bounds at once
  assign hit         = above_base && below_limit;
endmodule

// File: rtl/ap_offset.sv
module ap_offset #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-GRAN_W-1:0] base_g,
  input  logic                     hit,
  output logic [ADDR_W-1:0]        offset
);
  logic [ADDR_W-1:0] diff;
  assign diff   = addr - {base_g, {GRAN_W{1'b0}}};
  assign offset = hit ? diff : '0;
endmodule

// File: rtl/aperture_decoder.sv
module aperture_decoder #(
  parameter int          ADDR_W      = 32,
  parameter int          GRAN_W      = 16,
  parameter int          RA_W        = 21,
  parameter logic [RA_W-1:0] BASE_OFS  = 21'h10_0000,
  parameter logic [RA_W-1:0] LIMIT_OFS = 21'h10_0004,
  parameter int          RST_BASE_G  = 0,
  parameter int          RST_LIMIT_G = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam int GW = ADDR_W - GRAN_W;

  logic [GW-1:0] base_g;
  logic [GW-1:0] limit_g;

  ap_regfile #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .RA_W(RA_W),
    .BASE_OFS(BASE_OFS), .LIMIT_OFS(LIMIT_OFS),
    .RST_BASE_G(RST_BASE_G), .RST_LIMIT_G(RST_LIMIT_G)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data),
    .base_g(base_g), .limit_g(limit_g)
  );

  ap_window #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_win (
    .addr(addr), .base_g(base_g), .limit_g(limit_g), .hit(hit)
  );

  ap_offset #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_ofs (
    .addr(addr), .base_g(base_g), .hit(hit), .offset(offset)
  );
endmodule

// File: rtl/aperture_decoder_chk.sv
module aperture_decoder_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          GRAN_W    = 16,
  parameter int          RA_W      = 21,
  parameter logic [RA_W-1:0] BASE_OFS  = 21'h10_0000,
  parameter logic [RA_W-1:0] LIMIT_OFS = 21'h10_0004
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [RA_W-1:0]          reg_addr,
  input logic [ADDR_W-1:0]        wr_data,
  input logic [ADDR_W-1:0]        rd_data,
  input logic [ADDR_W-1:0]        addr,
  input logic                     hit,
  input logic [ADDR_W-1:0]        offset,
  input logic [ADDR_W-GRAN_W-1:0] base_g,
  input logic [ADDR_W-GRAN_W-1:0] limit_g
);
  logic [ADDR_W-1:0] base_a, limit_a;
  assign base_a  = {base_g,  {GRAN_W{1'b0}}};
  assign limit_a = {limit_g, {GRAN_W{1'b0}}};

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr >= base_a && addr < limit_a)); // R2
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_g <= base_g) |-> !hit); // R3
  AST_MISS_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (offset == '0)); // R4
  AST_OFS_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (offset < (limit_a - base_a))); // R4
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[GRAN_W-1:0] == '0); // R5
  AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == BASE_OFS) |=> (base_g == $past(wr_data[ADDR_W-1:GRAN_W]))); // R7
  AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == LIMIT_OFS) |=> (limit_g == $past(wr_data[ADDR_W-1:GRAN_W]))); // R7
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (reg_addr == BASE_OFS || reg_addr == LIMIT_OFS)) |=>
      ($stable(base_g) && $stable(limit_g))); // R6
endmodule

bind aperture_decoder aperture_decoder_chk #(
  .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .RA_W(RA_W),
  .BASE_OFS(BASE_OFS), .LIMIT_OFS(LIMIT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .rd_data(rd_data), .addr(addr), .hit(hit),
  .offset(offset), .base_g(base_g), .limit_g(limit_g)
);

// File: tb/sim_aperture_decoder.sv
`timescale 1ns/1ps
module sim_aperture_decoder;
  localparam int AW = 12;
  localparam int GB = 4;
  localparam int RW = 21;
  localparam logic [RW-1:0] OFS_B = 21'h10_0000;
  localparam logic [RW-1:0] OFS_L = 21'h10_0004;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [RW-1:0] reg_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] rd_data;
  logic [AW-1:0] addr = '0;
  logic          hit;
  logic [AW-1:0] offset;

  int n_chk = 0;
  int n_bad = 0;
  int n_print = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aperture_decoder #(
    .ADDR_W(AW), .GRAN_W(GB), .RA_W(RW),
    .BASE_OFS(OFS_B), .LIMIT_OFS(OFS_L),
    .RST_BASE_G(0), .RST_LIMIT_G('h10)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .addr(addr), .hit(hit),
    .offset(offset)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      if (n_print < 40) begin
        n_print++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h)", req, act, exp, addr);
      end
    end
  endtask

  task automatic wr(input logic [RW-1:0] ra, input int val);
    @(negedge clk);
    reg_addr = ra; wr_data = AW'(val); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [RW-1:0] ra, input int exp, input string req);
    @(negedge clk);
    reg_addr = ra;
    #1 check(req, int'(rd_data), exp);
  endtask

  // full address sweep; expected values derived from the granule bounds
  task automatic sweep(input int b, input int l, input string req);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      addr = AW'(a);
      #1;
      begin
        int g = a >> GB;
        int eh = (g >= b && g < l) ? 1 : 0;
        int eo = eh ? (a - (b << GB)) : 0;
        check(req, int'(hit), eh);
        check(req, int'(offset), eo);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values and reset window
    rd_chk(OFS_B, 0, "R1");
    rd_chk(OFS_L, 'h100, "R1");
    sweep(0, 'h10, "R1");

    // R5 low bits dropped on write, read as zero
    wr(OFS_B, 'h03F);
    wr(OFS_L, 'h2BA);
    rd_chk(OFS_B, 'h030, "R5");
    rd_chk(OFS_L, 'h2B0, "R5");
    // R8 non-power-of-two window of 0x28 granules
    sweep(3, 'h2B, "R8");

    // R6 unmapped offsets: read 0, writes ignored
    wr(21'h10_0008, 'hFFF);
    wr(21'h00_0000, 'hFFF);
    rd_chk(21'h10_0008, 0, "R6");
    rd_chk(21'h10_0002, 0, "R6");
    rd_chk(OFS_B, 'h030, "R6");
    rd_chk(OFS_L, 'h2B0, "R6");

    // R7 write takes effect only after the clock edge
    @(negedge clk);
    addr = 12'h2C5;
    reg_addr = OFS_L; wr_data = 12'h300; wr_en = 1'b1;
    #1 check("R7", int'(hit), 0);
    @(posedge clk); #1;
    check("R7", int'(hit), 1);
    check("R7", int'(offset), 'h2C5 - 'h30);
    @(negedge clk); wr_en = 1'b0;

    // R3 equal and inverted bounds
    wr(OFS_B, 'h200); wr(OFS_L, 'h200);
    sweep('h20, 'h20, "R3");
    wr(OFS_B, 'h500); wr(OFS_L, 'h100);
    sweep('h50, 'h10, "R3");

    // R2 whole space below the top granule, then a one-granule window
    wr(OFS_B, 'h000); wr(OFS_L, 'hFF0);
    sweep(0, 'hFF, "R2");
    wr(OFS_B, 'hFE0);
    sweep('hFE, 'hFF, "R8");
    // R4 offset on a mid-space single-granule window
    wr(OFS_B, 'h7A0); wr(OFS_L, 'h7B0);
    sweep('h7A, 'h7B, "R4");

    // R1 reset restores the default window
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(OFS_B, 0, "R1");
    rd_chk(OFS_L, 'h100, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule